// File: doc/BRIEF.md
# Panel Power-On Sequencer

This block brings an embedded display panel up in a fixed order. A software-visible configuration word is presented on a plain 32-bit input. It holds a two-bit selector for the display port that drives the panel and two 13-bit delay counts. When a power request arrives and the selected port is both enabled and attached to pipe B, the block first switches panel power on. It then waits out the combined supply-rise and link-settle interval, marks the panel ready, waits out the second interval, and finally enables the backlight.

Both waits are measured in 100 µs steps. A prescaler divides the input clock, whose frequency is a parameter, down to a one-cycle pulse every 100 µs, and only that pulse advances the wait counter. The selector and the backlight delay are captured when a sequence starts. The power-up delay is loaded into the counter at the same moment. Dropping the request, or losing the captured port's enable or pipe attachment, aborts the sequence at once and returns to the off state.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, panel_pwr_en, panel_ready, bklt_en and seq_busy are low and seq_state is 0 (off).
- R2: The port selector is cfg_word[31:30]. Code 01 names port index 0 (port B) and code 10 names port index 1 (port C). Codes 00 and 11 are reserved, and with a reserved code a power request never raises panel_pwr_en.
- R3: A power request raises nothing unless port_en and port_on_pipe are both high at the selected port's index.
- R4: With a valid port, panel_pwr_en rises and seq_state becomes 1 one clock after pwr_req is seen high in the off state, and seq_busy is high.
- R5: With D = CLK_HZ/10000 clocks per 100 µs step and N = cfg_word[28:16], panel_ready rises (seq_state 2) between N*D+1 and (N+1)*D clocks after panel_pwr_en rises. A count of zero leaves on the first step pulse.
- R6: With M = cfg_word[12:0], bklt_en rises exactly (M+1)*D clocks after panel_ready. At that point seq_state is 3 and seq_busy is low.
- R7: Dropping pwr_req in any non-off state clears all four enables and returns seq_state to 0 on the next clock.
- R8: If the captured port's enable or pipe-attachment input falls during a sequence, the block returns to off on the next clock and stays off while that port remains invalid.
- R9: The selector and both delays are taken when a sequence starts, so later changes to cfg_word do not alter the sequence in progress.
- R10: Bits 29 and 15:13 of cfg_word have no effect on behaviour.
- R11: bklt_en implies panel_ready, panel_ready implies panel_pwr_en, and seq_busy is high exactly in states 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running base clock of CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Port selector and the two delay counts |
| pwr_req | input | 1 | Request to power the panel up and keep it on |
| port_en | input | NUM_PORTS (2) | Per-port enabled status, index 0 = port B |
| port_on_pipe | input | NUM_PORTS (2) | Per-port attached-to-pipe-B status |
| panel_pwr_en | output | 1 | Panel supply enable |
| panel_ready | output | 1 | Power-up delay elapsed |
| bklt_en | output | 1 | Backlight enable |
| seq_busy | output | 1 | A wait is in progress |
| seq_state | output | 2 | 0 off, 1 power-up wait, 2 backlight wait, 3 on |

## Verification
The hardest situation to reach from the ports is a change in cfg_word that arrives while a wait is in progress, combined with the step pulse landing at an unknown phase relative to the request. The bench uses a four-clock step so that every phase occurs across a sweep of both selectors and small delay counts. It rewrites cfg_word to a different port and much longer delays just after panel_pwr_en rises, then checks the power-up interval against its phase window and the backlight interval against its exact arithmetic value. Aborts are forced separately in each wait state, both by dropping the request and by dropping the captured port's status.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // Layout of the configuration word. The bench and the requirements rely on it.
  localparam int CFG_W    = 32;
  localparam int SEL_HI   = 31;
  localparam int SEL_LO   = 30;
  localparam int SEL_W    = SEL_HI - SEL_LO + 1;
  localparam int PUD_HI   = 28;
  localparam int PUD_LO   = 16;
  localparam int BLD_HI   = 12;
  localparam int BLD_LO   = 0;
  localparam int DLY_W    = PUD_HI - PUD_LO + 1;
  localparam int STEP_HZ  = 10_000;   // one step = 100 us

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_PU_WAIT = 2'd1,
    ST_BL_WAIT = 2'd2,
    ST_ON      = 2'd3
  } seq_state_t;
endpackage

// File: rtl/pps_step_gen.sv
module pps_step_gen #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int STEP_HZ = 10_000
) (
  input  logic clk,
  input  logic rst,
  output logic step
);
  localparam int DIV = CLK_HZ / STEP_HZ;
  localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] div_q;

  initial begin
    if (DIV < 2) $error("pps_step_gen: CLK_HZ must be at least twice STEP_HZ");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      step  <= 1'b0;
    end else if (div_q == CW'(DIV - 1)) begin
      div_q <= '0;
      step  <= 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
      step  <= 1'b0;
    end
  end

  // The step is a single-cycle pulse (R5)
  assert_step_single_R5: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);
endmodule

// File: rtl/pps_port_check.sv
module pps_port_check #(
  parameter int NUM_PORTS = 2,
  parameter int SEL_W     = 2
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic [NUM_PORTS-1:0] port_en,
  input  logic [NUM_PORTS-1:0] port_on_pipe,
  output logic                 ok
);
  logic [NUM_PORTS-1:0] hit;

  // Code k+1 selects port index k; code 0 and codes above NUM_PORTS are reserved.
  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
    assign hit[gi] = (sel == SEL_W'(gi + 1)) & port_en[gi] & port_on_pipe[gi];
  end

  assign ok = |hit;
endmodule

// File: rtl/pps_delay_ctr.sv
module pps_delay_ctr #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (step && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // Only a load or a step may move the count (R9)
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(cnt_q));
  // A count at zero never wraps (R5)
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && zero) |=> zero);
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_W-1:0]     cfg_word,
  input  logic                 pwr_req,
  input  logic [NUM_PORTS-1:0] port_en,
  input  logic [NUM_PORTS-1:0] port_on_pipe,
  output logic                 panel_pwr_en,
  output logic                 panel_ready,
  output logic                 bklt_en,
  output logic                 seq_busy,
  output logic [1:0]           seq_state
);
  seq_state_t       state_q, state_d;
  logic [SEL_W-1:0] sel_live, sel_q;
  logic [DLY_W-1:0] pud_live, bld_live, bld_q;
  logic [DLY_W-1:0] load_val;
  logic             ok_live, ok_lat, step, zero, load, start, abort;
  logic             rsv_any;

  assign sel_live = cfg_word[SEL_HI:SEL_LO];
  assign pud_live = cfg_word[PUD_HI:PUD_LO];
  assign bld_live = cfg_word[BLD_HI:BLD_LO];
  assign rsv_any  = |{cfg_word[29], cfg_word[15:13]};

  pps_step_gen #(.CLK_HZ(CLK_HZ), .STEP_HZ(STEP_HZ)) u_step (
    .clk(clk), .rst(rst), .step(step)
  );

  pps_port_check #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_live_chk (
    .sel(sel_live), .port_en(port_en), .port_on_pipe(port_on_pipe), .ok(ok_live)
  );

  pps_port_check #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_lat_chk (
    .sel(sel_q), .port_en(port_en), .port_on_pipe(port_on_pipe), .ok(ok_lat)
  );

  pps_delay_ctr #(.W(DLY_W)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .step(step), .zero(zero)
  );

  assign abort = !pwr_req || !ok_lat;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = pud_live;
    start    = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (pwr_req && ok_live) begin
          state_d = ST_PU_WAIT;
          load    = 1'b1;
          start   = 1'b1;
        end
      end
      ST_PU_WAIT: begin
        if (abort) state_d = ST_OFF;
        else if (step && zero) begin
          state_d  = ST_BL_WAIT;
          load     = 1'b1;
          load_val = bld_q;
        end
      end
      ST_BL_WAIT: begin
        if (abort)             state_d = ST_OFF;
        else if (step && zero) state_d = ST_ON;
      end
      ST_ON: begin
        if (abort) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_OFF;
      sel_q        <= '0;
      bld_q        <= '0;
      panel_pwr_en <= 1'b0;
      panel_ready  <= 1'b0;
      bklt_en      <= 1'b0;
      seq_busy     <= 1'b0;
      seq_state    <= 2'd0;
    end else begin
      state_q <= state_d;
      if (start) begin
        sel_q <= sel_live;
        bld_q <= bld_live;
      end
      panel_pwr_en <= (state_d != ST_OFF);
      panel_ready  <= (state_d == ST_BL_WAIT) || (state_d == ST_ON);
      bklt_en      <= (state_d == ST_ON);
      seq_busy     <= (state_d == ST_PU_WAIT) || (state_d == ST_BL_WAIT);
      seq_state    <= state_d;
    end
  end

  // Reserved selector codes never start a sequence (R2)
  assert_rsv_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && (sel_live == 2'b00 || sel_live == 2'b11)) |=> state_q == ST_OFF);
  // An invalid port keeps the block off (R3)
  assert_bad_port_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && !ok_live) |=> !panel_pwr_en);
  // A valid request starts the sequence (R4)
  assert_start_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && pwr_req && ok_live) |=> (panel_pwr_en && seq_busy));
  // Request drop aborts from any active state (R7)
  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_OFF && !pwr_req) |=> (!panel_pwr_en && !bklt_en));
  // Loss of the captured port aborts (R8)
  assert_port_loss_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_OFF && !ok_lat) |=> state_q == ST_OFF);
  // The captured selector holds during a sequence (R9)
  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_OFF) |=> $stable(sel_q));
  // Reserved bits do not block a start (R10)
  assert_rsv_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && pwr_req && ok_live && rsv_any) |=> state_q == ST_PU_WAIT);
  // Backlight requires the earlier stages (R11)
  assert_order_R11: assert property (@(posedge clk) disable iff (rst)
    bklt_en |-> (panel_ready && panel_pwr_en));
  // The on state only leaves for off (R11)
  assert_on_exit_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON) |=> (state_q == ST_ON || state_q == ST_OFF));
endmodule

// File: tb/panel_pwr_seq_tb_top.sv
module panel_pwr_seq_tb_top;
  localparam int CLK_HZ = 40_000;
  localparam int D      = CLK_HZ / 10_000;   // clocks per step

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        pwr_req = 1'b0;
  logic [1:0]  port_en = 2'b11;
  logic [1:0]  port_on_pipe = 2'b11;
  logic        panel_pwr_en, panel_ready, bklt_en, seq_busy;
  logic [1:0]  seq_state;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  panel_pwr_seq #(.CLK_HZ(CLK_HZ), .NUM_PORTS(2)) dut_i (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .pwr_req(pwr_req),
    .port_en(port_en), .port_on_pipe(port_on_pipe),
    .panel_pwr_en(panel_pwr_en), .panel_ready(panel_ready), .bklt_en(bklt_en),
    .seq_busy(seq_busy), .seq_state(seq_state)
  );

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {28'd0, panel_pwr_en, panel_ready, bklt_en, seq_busy};
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] sel, input int pu, input int bl,
                                     input bit rsv);
    logic [31:0] w;
    w = {sel, 1'b0, 13'(pu), 3'b000, 13'(bl)};
    if (rsv) begin
      w[29]    = 1'b1;
      w[15:13] = 3'b111;
    end
    return w;
  endfunction

  // Full power-up with timing checks; starts and ends at a falling edge.
  task automatic run_case(input logic [1:0] sel, input int pu, input int bl,
                          input bit rsv, input bit chg);
    int t0, tp, tr, tb;
    bit order_ok;
    order_ok = 1'b1;
    tp = -1; tr = -1; tb = -1;
    cfg_word = mk(sel, pu, bl, rsv);
    port_en = 2'b11;
    port_on_pipe = 2'b11;
    pwr_req = 1'b1;
    t0 = cyc;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (panel_pwr_en && tp < 0) begin
        tp = cyc;
        if (chg) cfg_word = mk(~sel, 40, 40, 1'b0);
      end
      if (panel_ready && tr < 0) tr = cyc;
      if (bklt_en && !panel_ready) order_ok = 1'b0;
      if (panel_ready && !panel_pwr_en) order_ok = 1'b0;
      if (seq_busy != (seq_state == 2'd1 || seq_state == 2'd2)) order_ok = 1'b0;
      if (bklt_en) begin
        tb = cyc;
        break;
      end
    end
    chk(tp - t0 == 1, "R4 power enable latency", tp - t0, 1);
    chk(tr - tp >= pu * D + 1 && tr - tp <= (pu + 1) * D,
        chg ? "R9 power-up delay after cfg change" : (rsv ? "R10 power-up delay" : "R5 power-up delay"),
        tr - tp, (pu + 1) * D);
    chk(tb - tr == (bl + 1) * D,
        chg ? "R9 backlight delay after cfg change" : (rsv ? "R10 backlight delay" : "R6 backlight delay"),
        tb - tr, (bl + 1) * D);
    chk(seq_state == 2'd3 && !seq_busy, "R6 on state", {seq_state, seq_busy}, 6);
    chk(order_ok, "R11 output ordering", order_ok, 1);
    pwr_req = 1'b0;
    @(negedge clk);
    chk(outs() == 0 && seq_state == 0, "R7 drop in on state", outs(), 0);
    cfg_word = '0;
    @(negedge clk);
  endtask

  // Request with an invalid port setup: nothing may rise for 3 steps.
  task automatic refuse(input logic [1:0] sel, input logic [1:0] en, input logic [1:0] pp,
                        input string req);
    bit seen;
    seen = 1'b0;
    cfg_word = mk(sel, 0, 0, 1'b0);
    port_en = en;
    port_on_pipe = pp;
    pwr_req = 1'b1;
    for (int i = 0; i < 3 * D + 2; i++) begin
      @(negedge clk);
      if (panel_pwr_en || seq_state != 0) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
    pwr_req = 1'b0;
    port_en = 2'b11;
    port_on_pipe = 2'b11;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outs() == 0 && seq_state == 0, "R1 reset state", outs(), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(outs() == 0 && seq_state == 0, "R1 idle after reset", outs(), 0);

    // Sweep both ports and small delays so every step phase is hit
    for (int s = 1; s <= 2; s++)
      for (int pu = 0; pu <= 3; pu++)
        for (int bl = 0; bl <= 3; bl++)
          run_case(2'(s), pu, bl, 1'b0, 1'b0);

    run_case(2'b01, 2, 1, 1'b1, 1'b0);   // R10
    run_case(2'b10, 1, 2, 1'b1, 1'b0);   // R10
    run_case(2'b01, 2, 1, 1'b0, 1'b1);   // R9
    run_case(2'b10, 0, 3, 1'b0, 1'b1);   // R9

    // R2: reserved selector codes
    refuse(2'b00, 2'b11, 2'b11, "R2 selector 00 refused");
    refuse(2'b11, 2'b11, 2'b11, "R2 selector 11 refused");
    // R3: selected port disabled or off pipe B
    refuse(2'b01, 2'b10, 2'b11, "R3 port B disabled");
    refuse(2'b10, 2'b01, 2'b11, "R3 port C disabled");
    refuse(2'b01, 2'b11, 2'b10, "R3 port B not on pipe");
    refuse(2'b10, 2'b11, 2'b01, "R3 port C not on pipe");

    // R7: drop request during power-up wait
    cfg_word = mk(2'b01, 6, 6, 1'b0);
    pwr_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(seq_state == 1, "R7 in power-up wait", seq_state, 1);
    pwr_req = 1'b0;
    @(negedge clk);
    chk(outs() == 0 && seq_state == 0, "R7 drop in power-up wait", outs(), 0);
    @(negedge clk);

    // R7: drop request during backlight wait
    cfg_word = mk(2'b10, 0, 8, 1'b0);
    pwr_req = 1'b1;
    for (int i = 0; i < 50 && !panel_ready; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(seq_state == 2, "R7 in backlight wait", seq_state, 2);
    pwr_req = 1'b0;
    @(negedge clk);
    chk(outs() == 0 && seq_state == 0, "R7 drop in backlight wait", outs(), 0);
    @(negedge clk);

    // R8: pipe attachment lost during power-up wait
    cfg_word = mk(2'b01, 6, 2, 1'b0);
    pwr_req = 1'b1;
    repeat (3) @(negedge clk);
    port_on_pipe = 2'b10;
    @(negedge clk);
    chk(outs() == 0 && seq_state == 0, "R8 pipe loss aborts", outs(), 0);
    repeat (4) @(negedge clk);
    chk(!panel_pwr_en, "R8 stays off while invalid", panel_pwr_en, 0);
    pwr_req = 1'b0;
    port_on_pipe = 2'b11;
    @(negedge clk);

    // R8: port disabled while on
    cfg_word = mk(2'b10, 0, 0, 1'b0);
    pwr_req = 1'b1;
    for (int i = 0; i < 50 && !bklt_en; i++) @(negedge clk);
    chk(bklt_en == 1'b1, "R8 reached on", bklt_en, 1);
    port_en = 2'b01;
    @(negedge clk);
    chk(outs() == 0 && seq_state == 0, "R8 port disable aborts", outs(), 0);
    repeat (4) @(negedge clk);
    chk(!panel_pwr_en, "R8 stays off while disabled", panel_pwr_en, 0);
    pwr_req = 1'b0;
    port_en = 2'b11;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule